// File: doc/BRIEF.md
# SCSI Bus Arbitration Monitor

This block runs the bus-free check that precedes SCSI arbitration. Software starts it by writing the mode register with its two low bits set to `01`. The block then watches the busy (BSY) and select (SEL) lines of the bus. It does not act on either line straight away. Each line first passes through a deskew filter, so a new level counts only after it has held for a set number of clock cycles.

Once started, the block waits until the filtered BSY has stayed inactive for a settle interval, set as a parameter in clock cycles. Every BSY transition restarts that interval. When the interval runs out, the block samples the filtered SEL:
- If SEL is active, the block reports lost arbitration and leaves the bus alone.
- If SEL is inactive, the block asserts its own BSY output.

In both cases the monitor goes back to idle. The in-progress and lost flags feed a status register elsewhere in the chip. Software still has to wait before it reads the data bus to find out which ID won.

Writing the mode bits as `00` abandons arbitration and releases BSY. Writing either DMA pattern (`10` or `11`) stops the monitor and leaves the bus output as it was.

Top module: `scsi_arb_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bsy_out`, `arb_active` and `arb_lost` are 0.
- R2: A level on `bsy_in` or `sel_in` takes effect only after it differs from the accepted level at DESKEW_CYC consecutive rising edges. A pulse shorter than that has no effect on the outcome.
- R3: A mode write with `mode_bits` = `01` sets `arb_active` to 1 and `arb_lost` to 0 on the edge that samples the write, and the bus-free watch begins.
- R4: If both filtered lines are already inactive when the `01` write is sampled at edge w, `bsy_out` rises at edge w+SETTLE_CYC.
- R5: During the watch, if `bsy_in` goes low and edge 1 is the first edge to see it low, the decision falls on edge DESKEW_CYC+SETTLE_CYC. With SEL inactive, `bsy_out` rises on that edge.
- R6: A filtered BSY that becomes active again before the decision restarts the settle count. No decision is made until the line has been low for a full settle interval measured from its last release.
- R7: If the filtered SEL is active at the decision edge, `arb_lost` goes to 1, `bsy_out` stays 0 and the watch ends.
- R8: A mode write with `mode_bits` = `00` clears `arb_active`, drops `bsy_out` and ends any watch, so no later decision is made.
- R9: A mode write with `mode_bits` = `10` or `11` clears `arb_active` and ends any watch, and leaves `bsy_out` and `arb_lost` unchanged.
- R10: `arb_active` stays at 1 after a decision, until the next mode write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle strobe for a mode register write |
| mode_bits | input | 2 | Low two mode bits: 00 abort, 01 arbitrate, 1x DMA |
| bsy_in | input | 1 | BSY level on the bus, active high, synchronous to clk |
| sel_in | input | 1 | SEL level on the bus, active high, synchronous to clk |
| bsy_out | output | 1 | Request to drive BSY onto the bus |
| arb_active | output | 1 | Arbitration-in-progress flag |
| arb_lost | output | 1 | Lost-arbitration flag |

## Verification
The hardest case to reach from the ports is SEL changing in the few cycles around the settle decision. There the deskew delay and the settle count overlap, and a single-cycle error in either one flips the outcome. The bench starts each run from a known BSY release and sweeps the SEL onset across every cycle offset up to and beyond the decision edge. It also sweeps the SEL pulse width across the deskew threshold at two onsets. It checks both outputs on every cycle of each run, so the exact decision edge is pinned, not only the final result.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_WAIT = 1'b1
  } arb_state_e;

  localparam logic [1:0] MODE_ABORT = 2'b00;
  localparam logic [1:0] MODE_ARB   = 2'b01;

endpackage

// File: rtl/arb_line_filter.sv
// One bus line deglitcher: the accepted level follows the raw level only
// after the two have disagreed at DESKEW_CYC consecutive edges.
module arb_line_filter #(
  parameter int DESKEW_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(DESKEW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DESKEW_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R2: the accepted level only ever moves to a level the raw line held
  assert_filter_tracks_raw_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(raw_i)));

endmodule

// File: rtl/arb_settle_timer.sv
// Counts consecutive idle cycles of the filtered BSY while the watch runs.
module arb_settle_timer #(
  parameter int SETTLE_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic busy_i,
  output logic expire_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !busy_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run_i || busy_i || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: the count reached its end only if BSY was idle on the cycle before
  assert_expire_after_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (expire_o && (SETTLE_CYC > 1)) |-> $past(!busy_i));

endmodule

// File: rtl/scsi_arb_monitor.sv
module scsi_arb_monitor
  import scsi_arb_pkg::*;
#(
  parameter int DESKEW_CYC = 10,
  parameter int SETTLE_CYC = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_bits,
  input  logic       bsy_in,
  input  logic       sel_in,
  output logic       bsy_out,
  output logic       arb_active,
  output logic       arb_lost
);
  localparam int NLINES = 2;
  localparam int IDX_BSY = 0;
  localparam int IDX_SEL = 1;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              bsy_f;
  logic              sel_f;
  logic              expire;
  arb_state_e        state_q;
  logic              bsy_q;
  logic              active_q;
  logic              lost_q;

  assign raw_lines[IDX_BSY] = bsy_in;
  assign raw_lines[IDX_SEL] = sel_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    arb_line_filter #(.DESKEW_CYC(DESKEW_CYC)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  assign bsy_f = filt_lines[IDX_BSY];
  assign sel_f = filt_lines[IDX_SEL];

  arb_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (state_q == ARB_WAIT),
    .busy_i  (bsy_f),
    .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      bsy_q    <= 1'b0;
      active_q <= 1'b0;
      lost_q   <= 1'b0;
    end else if (mode_wr) begin
      active_q <= 1'b0;
      state_q  <= ARB_IDLE;
      if (mode_bits == MODE_ABORT) begin
        bsy_q <= 1'b0;
      end else if (mode_bits == MODE_ARB) begin
        state_q  <= ARB_WAIT;
        active_q <= 1'b1;
        lost_q   <= 1'b0;
      end
    end else if (expire) begin
      state_q <= ARB_IDLE;
      if (sel_f) lost_q <= 1'b1;
      else       bsy_q  <= 1'b1;
    end
  end

  assign bsy_out    = bsy_q;
  assign arb_active = active_q;
  assign arb_lost   = lost_q;

  assert_start_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_bits == MODE_ARB) |=> (arb_active && !arb_lost));

  assert_abort_release_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_bits == MODE_ABORT) |=> (!bsy_out && !arb_active));

  assert_grab_with_sel_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bsy_out) |-> ($past(state_q == ARB_WAIT) && !$past(sel_f)));

  assert_lost_from_sel_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> $past(sel_f));

  assert_active_on_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_active) |-> $past(mode_wr && mode_bits == MODE_ARB));

endmodule

// File: tb/tb_scsi_arb_monitor.sv
`timescale 1ns/1ps
module tb_scsi_arb_monitor;
  localparam int D = 3;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_wr;
  logic [1:0] mode_bits;
  logic       bsy_in;
  logic       sel_in;
  logic       bsy_out;
  logic       arb_active;
  logic       arb_lost;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  scsi_arb_monitor #(.DESKEW_CYC(D), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .bsy_in(bsy_in), .sel_in(sel_in), .bsy_out(bsy_out),
    .arb_active(arb_active), .arb_lost(arb_lost)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] b);
    mode_wr = 1'b1;
    mode_bits = b;
    tick();
    mode_wr = 1'b0;
  endtask

  // Bus busy, start, release BSY; SEL raised after sel_at edges for sel_w edges.
  task automatic run_case(input int sel_at, input int sel_w, input logic exp_lost);
    string req;
    req = exp_lost ? "R7" : "R5";
    write_mode(2'b00);
    bsy_in = 1'b1;
    sel_in = 1'b0;
    repeat (D + 2) tick();
    write_mode(2'b01);
    chk("R3", "active after start", arb_active, 1'b1);
    chk("R3", "lost after start", arb_lost, 1'b0);
    bsy_in = 1'b0;
    for (int n = 1; n <= D + S + 2; n++) begin
      if (n - 1 == sel_at) sel_in = 1'b1;
      if (n - 1 == sel_at + sel_w) sel_in = 1'b0;
      tick();
      chk(req, "bsy_out per edge", bsy_out, !exp_lost && (n >= D + S));
      chk(req, "lost per edge", arb_lost, exp_lost && (n >= D + S));
    end
    chk("R10", "active held after decision", arb_active, 1'b1);
    sel_in = 1'b0;
  endtask

  function automatic logic lost_expected(input int sel_at, input int sel_w);
    int j;
    j = sel_at + 1;
    return (sel_w >= D) && (j <= S) && (j + sel_w >= S + 1);
  endfunction

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    mode_wr = 1'b0;
    mode_bits = 2'b00;
    bsy_in = 1'b0;
    sel_in = 1'b0;
    repeat (3) tick();
    chk("R1", "bsy_out in reset", bsy_out, 1'b0);
    chk("R1", "active in reset", arb_active, 1'b0);
    chk("R1", "lost in reset", arb_lost, 1'b0);
    rst = 1'b0;
    tick();
    chk("R1", "bsy_out after reset", bsy_out, 1'b0);
    chk("R1", "active after reset", arb_active, 1'b0);

    // R4: start on an idle bus
    repeat (D + 2) tick();
    mode_wr = 1'b1;
    mode_bits = 2'b01;
    for (int n = 1; n <= S + 2; n++) begin
      tick();
      mode_wr = 1'b0;
      if (n == 1) chk("R3", "active on idle start", arb_active, 1'b1);
      chk("R4", "idle-bus grab edge", bsy_out, n >= S + 1);
    end

    // R9: DMA write after a win keeps BSY
    write_mode(2'b10);
    chk("R9", "bsy_out kept by DMA write", bsy_out, 1'b1);
    chk("R9", "active cleared by DMA write", arb_active, 1'b0);

    // R8: abort releases BSY
    write_mode(2'b00);
    chk("R8", "bsy_out released", bsy_out, 1'b0);
    chk("R8", "active cleared", arb_active, 1'b0);

    // R5 / R7: sweep SEL onset with SEL held
    for (int a = 0; a <= S + 2; a++) begin
      run_case(a, 1000, lost_expected(a, 1000));
    end

    // R2: sweep SEL pulse width across the deskew threshold
    for (int w = 1; w <= D + 2; w++) begin
      run_case(S - 1, w, lost_expected(S - 1, w));
      run_case(0, w, lost_expected(0, w));
    end

    // R9: DMA write keeps a lost flag
    run_case(0, 1000, 1'b1);
    write_mode(2'b11);
    chk("R9", "lost kept by DMA write", arb_lost, 1'b1);
    chk("R9", "active cleared", arb_active, 1'b0);

    // R9: DMA write during the watch stops it
    write_mode(2'b00);
    bsy_in = 1'b0;
    sel_in = 1'b0;
    repeat (D + 2) tick();
    write_mode(2'b01);
    write_mode(2'b10);
    repeat (S + 4) tick();
    chk("R9", "no grab after DMA write", bsy_out, 1'b0);
    chk("R9", "active off after DMA write", arb_active, 1'b0);

    // R8: abort during the watch stops it
    bsy_in = 1'b1;
    repeat (D + 2) tick();
    write_mode(2'b01);
    write_mode(2'b00);
    bsy_in = 1'b0;
    repeat (D + S + 4) tick();
    chk("R8", "no grab after abort", bsy_out, 1'b0);
    chk("R8", "no lost after abort", arb_lost, 1'b0);
    chk("R8", "active off after abort", arb_active, 1'b0);

    // R6: BSY returns before the decision, the count restarts
    bsy_in = 1'b1;
    repeat (D + 2) tick();
    write_mode(2'b01);
    bsy_in = 1'b0;
    repeat (S - 1) tick();
    bsy_in = 1'b1;
    repeat (D + 2) tick();
    chk("R6", "no grab after short release", bsy_out, 1'b0);
    bsy_in = 1'b0;
    for (int n = 1; n <= D + S + 1; n++) begin
      tick();
      chk("R6", "grab edge after restart", bsy_out, n >= D + S);
    end

    // R2: a short BSY dip while busy does not start the count
    write_mode(2'b00);
    bsy_in = 1'b1;
    repeat (D + 2) tick();
    write_mode(2'b01);
    for (int k = 0; k < 2 * S; k++) begin
      bsy_in = 1'b0;
      repeat (D - 1) tick();
      bsy_in = 1'b1;
      tick();
    end
    chk("R2", "dips below deskew ignored", bsy_out, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule